// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a slave on a two-wire serial bus. Behind it sits a 256-byte memory. The engine runs on a fast system clock and samples the raw clock and data lines through a synchronizer. It recognises bus Start and Stop conditions and shifts in a control byte, which it checks against a fixed device code. After that it either takes a word address followed by data bytes (a write) or shifts stored bytes out most-significant bit first (a read).

The engine never drives the data line high. It asserts one output-enable signal that pulls the line low, and it uses that signal both for acknowledges and for the zero bits of read data. Each received write byte goes out as a one-cycle request to an external page buffer. A Stop that ends a write with at least one data byte produces a commit pulse. An external busy flag from the write-cycle logic stops all acknowledges while the array is programming.

Top module: `serial_mem_slave`

## Requirements
- R1: A fall of the data line while the clock line is high is a Start. It restarts control-byte reception from any state and discards a partly received byte. A rise of the data line while the clock line is high is a Stop, and it returns the engine to idle.
- R2: The first byte after a Start is the control byte. It matches when bits 7:4 equal binary 1010; bits 3:1 have no effect. Bit 0 selects a read (1) or a write (0). On a match the engine holds the data line low for the whole high phase of the ninth clock.
- R3: When the control byte does not match, the engine gives no acknowledge, issues no write request and ignores every later byte until the next Start.
- R4: In a write, the second byte is loaded in full into the 8-bit address pointer and acknowledged. A read that follows a repeated Start begins at that address.
- R5: Each data byte received in a write is acknowledged. It is presented for exactly one cycle on wrValid, with wrAddr equal to the current pointer and wrData equal to the byte.
- R6: After each written byte only pointer bits 2:0 advance, wrapping inside the aligned 8-byte page. Bits 7:3 stay fixed, so more than eight bytes overwrite earlier page positions.
- R7: A Stop that ends a write with at least one acknowledged data byte produces a single one-cycle wrCommit pulse. A Stop with no data byte, and a transfer aborted by a Start, produce none.
- R8: While busy is high, the engine acknowledges no byte, the control byte included, and ignores the bus until the next Start.
- R9: In a read, each byte is the memory content at rdAddr, sent most-significant bit first. The pointer then advances by one and wraps from FF to 00.
- R10: When the master leaves the acknowledge slot of a read byte high, the engine releases the data line and keeps it released until the next Start or Stop.
- R11: The output enable changes only in the cycle after a detected clock fall, Start or Stop, and never while the synchronized clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line (resolved bus level) |
| sdaOe | output | 1 | 1 pulls the data line low |
| busy | input | 1 | Internal programming cycle in progress |
| rdAddr | output | 8 | Memory read address (address pointer) |
| rdData | input | 8 | Memory content at rdAddr |
| wrValid | output | 1 | One-cycle write request to the page buffer |
| wrAddr | output | 8 | Address of the write request |
| wrData | output | 8 | Data of the write request |
| wrCommit | output | 1 | One-cycle pulse that starts the internal write cycle |

## Verification
Bound properties check on every cycle that the output enable moves only after a clock fall, Start or Stop and stays frozen while the clock is high. They also check that every write request is followed by an acknowledge drive, that a commit follows a Stop, and that a request and a commit never coincide. Only the bench scenarios can show the rest. These are the control-code match that ignores the select bits, the silence under busy and after a mismatch, page wrap of write addresses, pointer wrap across FF in reads, the release after a master no-acknowledge, and the abort of a write by a repeated Start.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } engState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrFrame;  // restart bit framing, release line
    logic ackDrive;  // pull line low for acknowledge
    logic relSda;    // release line
    logic loadPtr;   // pointer <= received byte
    logic incPtr;    // full pointer increment (read)
    logic incPage;   // low page bits increment (write)
    logic loadTx;    // load read byte, drive its MSB
    logic shiftTx;   // drive next read bit
  } dpCmd_t;
endpackage

// File: rtl/twb_datapath.sv
module twb_datapath
  import twb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] rdData,
  output logic              evStart,
  output logic              evStop,
  output logic              evFall,
  output logic [3:0]        bitCnt,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackBit,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe,
  output logic              sclLvl
);
  localparam logic [3:0] LAST_BIT = 4'(DATA_W);
  localparam logic [3:0] ACK_BIT  = 4'(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD, evRise;
  logic [DATA_W-1:0] txReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclLvl  = sclS;
  assign evRise  = sclS & ~sclD;
  assign evFall  = ~sclS & sclD;
  assign evStart = sclS & sclD & sdaD & ~sdaS;
  assign evStop  = sclS & sclD & ~sdaD & sdaS;

  // bit framing and receive shift register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
      ackBit <= 1'b1;
    end else if (cmd.clrFrame) begin
      bitCnt <= '0;
    end else begin
      if (evRise && bitCnt < ACK_BIT) bitCnt <= bitCnt + 4'd1;
      else if (evFall && bitCnt == ACK_BIT) bitCnt <= '0;
      if (evRise && bitCnt < LAST_BIT) rxByte <= {rxByte[DATA_W-2:0], sdaS};
      if (evRise && bitCnt == LAST_BIT) ackBit <= sdaS;
    end
  end

  // address pointer
  generate
    if (PAGE_BITS < ADDR_W) begin : g_paged
      always_ff @(posedge clk) begin
        if (!rstN) ptr <= '0;
        else if (cmd.loadPtr) ptr <= rxByte[ADDR_W-1:0];
        else if (cmd.incPtr) ptr <= ptr + 1'b1;
        else if (cmd.incPage)
          ptr <= {ptr[ADDR_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
      end
    end else begin : g_flat
      always_ff @(posedge clk) begin
        if (!rstN) ptr <= '0;
        else if (cmd.loadPtr) ptr <= rxByte[ADDR_W-1:0];
        else if (cmd.incPtr || cmd.incPage) ptr <= ptr + 1'b1;
      end
    end
  endgenerate

  // open-drain output and read shift register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
      txReg <= '0;
    end else if (cmd.clrFrame || cmd.relSda) begin
      sdaOe <= 1'b0;
    end else if (cmd.ackDrive) begin
      sdaOe <= 1'b1;
    end else if (cmd.loadTx) begin
      txReg <= rdData;
      sdaOe <= ~rdData[DATA_W-1];
    end else if (cmd.shiftTx) begin
      txReg <= {txReg[DATA_W-2:0], 1'b0};
      sdaOe <= ~txReg[DATA_W-2];
    end
  end
endmodule

// File: rtl/twb_control.sv
module twb_control
  import twb_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int         DATA_W   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evFall,
  input  logic [3:0] bitCnt,
  input  logic [3:0] codeNib,
  input  logic       rwBit,
  input  logic       ackBit,
  output dpCmd_t     cmd,
  output logic       wrValid,
  output logic       wrCommit
);
  localparam logic [3:0] LAST_BIT = 4'(DATA_W);
  localparam logic [3:0] ACK_BIT  = 4'(DATA_W + 1);

  engState_t state, nxt;
  logic dataSeen, setSeen;

  always_comb begin
    cmd     = '0;
    nxt     = state;
    wrValid = 1'b0;
    setSeen = 1'b0;
    if (evStart) begin
      cmd.clrFrame = 1'b1;
      nxt = ST_CTRL;
    end else if (evStop) begin
      cmd.clrFrame = 1'b1;
      nxt = ST_IDLE;
    end else if (evFall) begin
      unique case (state)
        ST_CTRL: if (bitCnt == LAST_BIT) begin
          if (codeNib == DEV_CODE && !busy) begin
            cmd.ackDrive = 1'b1;
            nxt = rwBit ? ST_RDATA : ST_ADDR;
          end else nxt = ST_IGNORE;
        end
        ST_ADDR: if (bitCnt == LAST_BIT) begin
          if (!busy) begin
            cmd.ackDrive = 1'b1;
            cmd.loadPtr  = 1'b1;
            nxt = ST_WDATA;
          end else nxt = ST_IGNORE;
        end else if (bitCnt == ACK_BIT) cmd.relSda = 1'b1;
        ST_WDATA: if (bitCnt == LAST_BIT) begin
          if (!busy) begin
            cmd.ackDrive = 1'b1;
            cmd.incPage  = 1'b1;
            wrValid      = 1'b1;
            setSeen      = 1'b1;
          end else nxt = ST_IGNORE;
        end else if (bitCnt == ACK_BIT) cmd.relSda = 1'b1;
        ST_RDATA: if (bitCnt == LAST_BIT) begin
          cmd.relSda = 1'b1;
          cmd.incPtr = 1'b1;
        end else if (bitCnt == ACK_BIT) begin
          if (!ackBit) cmd.loadTx = 1'b1;
          else begin
            cmd.relSda = 1'b1;
            nxt = ST_IGNORE;
          end
        end else if (bitCnt != 4'd0) cmd.shiftTx = 1'b1;
        default: if (bitCnt == ACK_BIT) cmd.relSda = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dataSeen <= 1'b0;
      wrCommit <= 1'b0;
    end else begin
      state    <= nxt;
      wrCommit <= evStop && dataSeen && state == ST_WDATA;
      if (evStart || evStop) dataSeen <= 1'b0;
      else if (setSeen) dataSeen <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import twb_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter int         PAGE_BITS   = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              busy,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrCommit
);
  dpCmd_t cmd;
  logic evStart, evStop, evFall, ackBit, sclLvl;
  logic [3:0] bitCnt;
  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] ptr;

  twb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PAGE_BITS(PAGE_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cmd(cmd), .rdData(rdData),
    .evStart(evStart), .evStop(evStop), .evFall(evFall),
    .bitCnt(bitCnt), .rxByte(rxByte), .ackBit(ackBit),
    .ptr(ptr), .sdaOe(sdaOe), .sclLvl(sclLvl)
  );

  twb_control #(.DEV_CODE(DEV_CODE), .DATA_W(DATA_W)) i_ctl (
    .clk(clk), .rstN(rstN), .busy(busy),
    .evStart(evStart), .evStop(evStop), .evFall(evFall),
    .bitCnt(bitCnt), .codeNib(rxByte[DATA_W-1:DATA_W-4]),
    .rwBit(rxByte[0]), .ackBit(ackBit),
    .cmd(cmd), .wrValid(wrValid), .wrCommit(wrCommit)
  );

  assign rdAddr = ptr;
  assign wrAddr = ptr;
  assign wrData = rxByte;
endmodule

// File: rtl/twb_checker.sv
module twb_checker (
  input logic clk,
  input logic rstN,
  input logic sclLvl,
  input logic evFall,
  input logic evStart,
  input logic evStop,
  input logic sdaOe,
  input logic wrValid,
  input logic wrCommit
);
  p_oe_moves_on_event_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(evFall || evStart || evStop));

  p_oe_frozen_scl_high_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl)) |-> $stable(sdaOe));

  p_ack_follows_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> sdaOe);

  p_commit_after_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(evStop));

  p_req_commit_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrValid, wrCommit}));
endmodule

bind serial_mem_slave twb_checker i_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .evFall(evFall),
  .evStart(evStart), .evStop(evStop), .sdaOe(sdaOe),
  .wrValid(wrValid), .wrCommit(wrCommit)
);

// File: tb/test_serial_mem_slave.sv
module test_serial_mem_slave;
  localparam int HP = 8;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, busy = 1'b0;
  logic sdaOe, wrValid, wrCommit, sdaLine;
  logic [7:0] rdAddr, rdData, wrAddr, wrData;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  logic [7:0] logA [64];
  logic [7:0] logD [64];
  logic [7:0] txBuf [16];
  int checks = 0, fails = 0, wrN = 0, commitN = 0, oeViol = 0;
  bit finished = 1'b0;
  logic prevScl = 1'b1, prevOe = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  assign sdaLine = sdaM & ~sdaOe;
  assign rdData  = mem[rdAddr];

  serial_mem_slave i_serial_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .busy(busy), .rdAddr(rdAddr), .rdData(rdData), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit)
  );

  // page buffer model and observers
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      if (wrN < 64) begin logA[wrN] = wrAddr; logD[wrN] = wrData; end
      mem[wrAddr] = wrData;
      wrN++;
    end
    if (rstN && wrCommit) commitN++;
    if (rstN && sclM && prevScl && sdaOe != prevOe) oeViol++;  // R11
    prevScl = sclM;
    prevOe  = sdaOe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n = HP);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; wt(); sclM = 1'b1; wt(); sdaM = 1'b0; wt(); sclM = 1'b0; wt();
  endtask

  task automatic busStop;
    sdaM = 1'b0; wt(); sclM = 1'b1; wt(); sdaM = 1'b1; wt();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; wt(); sclM = 1'b1; wt(); sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit lowA, lowB;
    sendBits(b, 8);
    sdaM = 1'b1; wt(); sclM = 1'b1;
    wt(1); lowA = !sdaLine; wt(HP - 1); lowB = !sdaLine;
    sclM = 1'b0;
    acked = lowA && lowB;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(); sclM = 1'b1; wt(HP / 2); b[i] = sdaLine; wt(HP - HP / 2); sclM = 1'b0;
    end
    sdaM = giveAck ? 1'b0 : 1'b1;
    wt(); sclM = 1'b1; wt(); sclM = 1'b0; wt(2); sdaM = 1'b1;
  endtask

  // full write transaction from txBuf, with expectations
  task automatic doWrite(input logic [2:0] sel, input logic [7:0] addr, input int n);
    bit a;
    int w0 = wrN, c0 = commitN;
    logic [7:0] ea;
    busStart;
    sendByte({4'b1010, sel, 1'b0}, a); chk(a, "R2 write control ack", a, 1);
    sendByte(addr, a);                 chk(a, "R4 address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(txBuf[i], a);           chk(a, "R5 data ack", a, 1);
    end
    busStop; wt(2);
    chk(wrN - w0 == n, "R5 request count", wrN - w0, n);
    for (int i = 0; i < n && w0 + i < 64; i++) begin
      ea = {addr[7:3], 3'(addr[2:0] + 3'(i))};
      chk(logA[w0 + i] == ea, "R6 request address", logA[w0 + i], ea);
      chk(logD[w0 + i] == txBuf[i], "R5 request data", logD[w0 + i], txBuf[i]);
      expMem[ea] = txBuf[i];
    end
    chk(commitN - c0 == 1, "R7 commit on stop", commitN - c0, 1);
  endtask

  // random read: set pointer, repeated start, read n bytes, nack last
  task automatic doRead(input logic [2:0] sel, input logic [7:0] addr, input int n,
                        input bit probeRelease);
    bit a;
    int c0 = commitN, lowSeen = 0;
    logic [7:0] got, ea;
    busStart;
    sendByte({4'b1010, sel, 1'b0}, a); chk(a, "R2 control ack", a, 1);
    sendByte(addr, a);                 chk(a, "R4 address ack", a, 1);
    busStart;
    sendByte({4'b1010, ~sel, 1'b1}, a); chk(a, "R2 read control ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, got);
      ea = expMem[8'(addr + 8'(i))];
      chk(got == ea, "R9 read data", got, ea);
    end
    if (probeRelease) begin
      for (int k = 0; k < 9; k++) begin
        wt(); sclM = 1'b1; wt(1); if (!sdaLine) lowSeen++;
        wt(HP - 1); if (!sdaLine) lowSeen++; sclM = 1'b0;
      end
      chk(lowSeen == 0, "R10 line released after no-ack", lowSeen, 0);
    end
    busStop; wt(2);
    chk(commitN == c0, "R7 no commit on read", commitN - c0, 0);
  endtask

  initial begin
    bit a;
    int w0, c0;
    logic [7:0] got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 7 + 3) ^ 8'h5A);
      expMem[i] = mem[i];
    end
    wt(5); rstN = 1'b1; wt(2);
    chk(sdaOe == 1'b0 && wrValid == 1'b0 && wrCommit == 1'b0, "R1 reset outputs",
        {sdaOe, wrValid, wrCommit}, 0);
    chk(rdAddr == 8'h00, "R9 reset pointer", rdAddr, 0);

    // single byte write, block-select bits set
    txBuf[0] = 8'hC3;
    doWrite(3'b111, 8'h42, 1);
    // page write past eight bytes from mid-page
    for (int i = 0; i < 10; i++) txBuf[i] = 8'(8'h10 + i * 3);
    doWrite(3'b010, 8'h35, 10);
    // read wrapping across FF
    doRead(3'b000, 8'hFE, 4, 1'b1);
    doRead(3'b101, 8'h30, 8, 1'b0);

    // mismatching control code: silent, no requests
    w0 = wrN; c0 = commitN;
    busStart;
    sendByte(8'h50, a); chk(!a, "R3 no ack on mismatch", a, 0);
    sendByte(8'h12, a); chk(!a, "R3 later byte ignored", a, 0);
    sendByte(8'h34, a); chk(!a, "R3 later byte ignored", a, 0);
    busStop; wt(2);
    chk(wrN == w0 && commitN == c0, "R3 no request", wrN - w0, 0);

    // busy: no acknowledge, not even the control byte
    busy = 1'b1;
    busStart;
    sendByte(8'hA0, a); chk(!a, "R8 no ack while busy", a, 0);
    sendByte(8'h20, a); chk(!a, "R8 bus ignored while busy", a, 0);
    busStop;
    busStart;
    sendByte(8'hA1, a); chk(!a, "R8 no read ack while busy", a, 0);
    busStop;
    busy = 1'b0; wt(2);
    chk(wrN == w0, "R8 no request while busy", wrN - w0, 0);

    // address only, then current-address read
    c0 = commitN;
    busStart;
    sendByte(8'hA4, a); sendByte(8'h77, a); chk(a, "R4 address ack", a, 1);
    busStop; wt(2);
    chk(commitN == c0, "R7 no commit without data", commitN - c0, 0);
    busStart;
    sendByte(8'hA1, a); chk(a, "R2 read control ack", a, 1);
    recvByte(1'b0, got);
    chk(got == expMem[8'h77], "R4 pointer loaded", got, expMem[8'h77]);
    busStop;

    // start aborts a write mid-byte
    w0 = wrN; c0 = commitN;
    busStart;
    sendByte(8'hA0, a); sendByte(8'h10, a);
    sendBits(8'hF0, 4);
    busStart;
    sendByte(8'hA1, a); chk(a, "R1 restart control ack", a, 1);
    recvByte(1'b0, got);
    chk(got == expMem[8'h10], "R1 abort keeps pointer", got, expMem[8'h10]);
    busStop; wt(2);
    chk(wrN == w0 && commitN == c0, "R1 aborted write no request", wrN - w0, 0);

    // random mix
    for (int t = 0; t < 14; t++) begin
      logic [7:0] ad;
      int n;
      ad = 8'($urandom);
      n  = 1 + int'($urandom % 10);
      if ($urandom % 2 == 0) begin
        for (int i = 0; i < n; i++) txBuf[i] = 8'($urandom);
        doWrite(3'($urandom), ad, n);
      end else begin
        doRead(3'($urandom), ad, n, 1'b0);
      end
    end

    chk(oeViol == 0, "R11 output steady while clock high", oeViol, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule